// File: doc/BRIEF.md
# Wake Event Signal Controller

This block turns wake-up event detections into an external wake signal and an internal interrupt flag. An upstream detector supplies a one-cycle strobe each time it recognises a wake frame or magic packet. A small register holds the configuration bits and a sticky status bit. Software clears the status bit by writing one to it.

The external signal drives a pad that is modelled as a drive-enable output and a data output. It can behave in two ways. In pulse mode it is active for a fixed time, nominally 50 ms, counted from the block clock. In level mode it stays active until software releases it. In push-pull mode the polarity is programmable. In open-drain mode the pad only ever pulls low, and only while the signal is active.

A three-state machine controls the signal. Its states are `ST_IDLE` (signal released), `ST_PULSE` (timed assertion) and `ST_HOLD` (level assertion). The transitions are:
- **start**: `ST_IDLE` to `ST_PULSE` or `ST_HOLD`, on an accepted event while the pin is enabled.
- **retrigger**: an accepted event while active re-enters `ST_PULSE` with a fresh timer, or enters `ST_HOLD`.
- **expire**: `ST_PULSE` to `ST_IDLE` when the timer reaches zero.
- **release**: `ST_PULSE` or `ST_HOLD` to `ST_IDLE` when the status bit, the wake enable or the pin enable is low.

Top module: `wake_signal_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, `irq_flag` is 0, and `pad_oe` and `pad_out` are 0.
- R2: A `wake_evt` strobe while wake enable (bit 5) is 1 sets the status bit (bit 3) and `irq_flag` at the next edge, whatever the pin enable (bit 0) holds.
- R3: A `wake_evt` strobe while wake enable is 0 changes neither the status bit nor the pad outputs.
- R4: With level mode (bit 2) at 0, an accepted event with pin enabled keeps the signal active for exactly PULSE_MS x CLK_HZ / 1000 cycles, starting the cycle after the strobe.
- R5: With level mode at 1, an accepted event with pin enabled keeps the signal active until it is released.
- R6: Writing 1 to bit 3 clears the status bit and releases the signal. Writing 0 to bit 3 has no effect. An accepted event in the same cycle as a clearing write leaves the status bit set.
- R7: Clearing the pin enable or the wake enable releases the signal at the next edge.
- R8: With push-pull (bit 4) at 0, the pad is open-drain: `pad_oe` is 1 only while the signal is active, `pad_out` is always 0, and the polarity bit (bit 1) is ignored.
- R9: With push-pull at 1 and pin enabled, `pad_oe` is 1. `pad_out` equals the polarity bit while the signal is active and its inverse otherwise.
- R10: An accepted event during a pulse restarts the full pulse length.
- R11: With pin enable at 0, `pad_oe` and `pad_out` stay 0, but the status bit still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_evt | input | 1 | One-cycle wake detection strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Write data: bit0 pin enable, bit1 active-high, bit2 level mode, bit3 status clear (write one), bit4 push-pull, bit5 wake enable |
| reg_rdata | output | 6 | Register read-back, same layout, bit3 shows status |
| irq_flag | output | 1 | Interrupt status flag (mirrors status bit) |
| pad_oe | output | 1 | Pad drive enable |
| pad_out | output | 1 | Pad drive value |

## Verification
On every cycle, the assertions check the status bit's set, hold and clear rules, the pin-disabled and open-drain pad restrictions, the bound on the pulse counter and its reload on a retrigger, and that a hold is not left without a cause. Only the bench's scenarios can show the exact pulse length, the polarity seen in each drive mode, the precedence of an event over a clearing write, and the release caused by each enable. The bench shows these by comparing a behavioural model on every cycle.

// File: rtl/wake_sig_pkg.sv
package wake_sig_pkg;

    localparam int REG_W       = 6;
    localparam int BIT_PIN_EN  = 0;
    localparam int BIT_POL_HI  = 1;
    localparam int BIT_LEVEL   = 2;
    localparam int BIT_STATUS  = 3;
    localparam int BIT_PUSHPL  = 4;
    localparam int BIT_WAKE_EN = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } wake_state_e;

    typedef struct packed {
        logic wake_en;
        logic push_pull;
        logic level_mode;
        logic active_high;
        logic pin_en;
    } wake_cfg_t;

endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
    import wake_sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_accept,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output wake_cfg_t        cfg,
    output logic             status,
    output logic [REG_W-1:0] reg_rdata
);

    logic status_clr;

    assign status_clr = reg_wr && reg_wdata[BIT_STATUS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (reg_wr) begin
            cfg.pin_en      <= reg_wdata[BIT_PIN_EN];
            cfg.active_high <= reg_wdata[BIT_POL_HI];
            cfg.level_mode  <= reg_wdata[BIT_LEVEL];
            cfg.push_pull   <= reg_wdata[BIT_PUSHPL];
            cfg.wake_en     <= reg_wdata[BIT_WAKE_EN];
        end
    end

    // set has priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (evt_accept) begin
            status <= 1'b1;
        end else if (status_clr) begin
            status <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[BIT_PIN_EN]  = cfg.pin_en;
        reg_rdata[BIT_POL_HI]  = cfg.active_high;
        reg_rdata[BIT_LEVEL]   = cfg.level_mode;
        reg_rdata[BIT_STATUS]  = status;
        reg_rdata[BIT_PUSHPL]  = cfg.push_pull;
        reg_rdata[BIT_WAKE_EN] = cfg.wake_en;
    end

    // R2: accepted event always sets status
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_accept |=> status);

    // R3: without an accepted event a clear status stays clear
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !evt_accept) |=> !status);

    // R6: write-one clears when no event competes
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[BIT_STATUS] && !evt_accept) |=> !status);

    // R6: writing zero to status keeps it
    a_r6_w0_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !(reg_wr && reg_wdata[BIT_STATUS])) |=> status);

endmodule

// File: rtl/wake_pulse_timer.sv
module wake_pulse_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R4: counter never exceeds the pulse length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);

    // R10: a (re)start always reloads the full count
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == RELOAD));

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_sig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_accept,
    input  wake_cfg_t   cfg,
    input  logic        status,
    input  logic        timer_done,
    output logic        timer_load,
    output logic        timer_dec,
    output logic        sig_active
);

    wake_state_e state, state_nx;
    logic        release_req;
    logic        start;

    assign release_req = !status || !cfg.wake_en || !cfg.pin_en;
    assign start       = evt_accept && cfg.pin_en;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    state_nx = cfg.level_mode ? ST_HOLD : ST_PULSE;
            end
            ST_PULSE: begin
                if (release_req)
                    state_nx = ST_IDLE;
                else if (start)
                    state_nx = cfg.level_mode ? ST_HOLD : ST_PULSE;
                else if (timer_done)
                    state_nx = ST_IDLE;
            end
            ST_HOLD: begin
                if (release_req)
                    state_nx = ST_IDLE;
                else if (start)
                    state_nx = cfg.level_mode ? ST_HOLD : ST_PULSE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        timer_load = 1'b0;
        timer_dec  = 1'b0;
        sig_active = 1'b0;
        unique case (state)
            ST_IDLE: begin
                timer_load = start && !cfg.level_mode;
            end
            ST_PULSE: begin
                timer_load = !release_req && start && !cfg.level_mode;
                timer_dec  = 1'b1;
                sig_active = !release_req;
            end
            ST_HOLD: begin
                timer_load = !release_req && start && !cfg.level_mode;
                sig_active = !release_req;
            end
            default: ;
        endcase
    end

    // R5: a hold persists while nothing releases or converts it
    a_r5_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !release_req && !(start && !cfg.level_mode))
        |=> (state == ST_HOLD));

    // R7: a release condition always ends the active state
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && release_req) |=> (state == ST_IDLE));

endmodule

// File: rtl/wake_signal_ctrl.sv
module wake_signal_ctrl
    import wake_sig_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int PULSE_MS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_evt,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_flag,
    output logic             pad_oe,
    output logic             pad_out
);

    localparam int PULSE_CYC_RAW = (CLK_HZ / 1000) * PULSE_MS;
    localparam int PULSE_CYC     = (PULSE_CYC_RAW < 1) ? 1 : PULSE_CYC_RAW;

    wake_cfg_t cfg;
    logic      status;
    logic      evt_accept;
    logic      timer_load, timer_dec, timer_done;
    logic      sig_active;

    assign evt_accept = wake_evt && cfg.wake_en;

    wake_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_accept (evt_accept),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .cfg        (cfg),
        .status     (status),
        .reg_rdata  (reg_rdata)
    );

    wake_pulse_timer #(.CYCLES(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .dec   (timer_dec),
        .done  (timer_done)
    );

    wake_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_accept (evt_accept),
        .cfg        (cfg),
        .status     (status),
        .timer_done (timer_done),
        .timer_load (timer_load),
        .timer_dec  (timer_dec),
        .sig_active (sig_active)
    );

    assign irq_flag = status;

    always_comb begin
        pad_oe  = 1'b0;
        pad_out = 1'b0;
        if (cfg.pin_en) begin
            if (cfg.push_pull) begin
                pad_oe  = 1'b1;
                pad_out = sig_active ? cfg.active_high : !cfg.active_high;
            end else begin
                pad_oe  = sig_active;
                pad_out = 1'b0;
            end
        end
    end

    // R8: open-drain never drives high
    a_r8_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.push_pull && pad_oe) |-> !pad_out);

    // R11: disabled pin stays quiet
    a_r11_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.pin_en |-> (!pad_oe && !pad_out));

    // R9: push-pull keeps the driver on
    a_r9_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.push_pull && cfg.pin_en) |-> pad_oe);

    // R6: once status falls the signal is released
    a_r6_status_release: assert property (@(posedge clk) disable iff (!rst_n)
        !status |-> !sig_active);

endmodule

// File: tb/wake_signal_ctrl_test.sv
module wake_signal_ctrl_test;

    localparam int N = 6;  // CLK_HZ 1000, PULSE_MS 6 -> 6 cycles
    localparam logic [5:0] PIN = 6'h01, HI = 6'h02, LVL = 6'h04,
                           STS = 6'h08, PP = 6'h10, WK = 6'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_evt = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic       irq_flag, pad_oe, pad_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    wake_signal_ctrl #(.CLK_HZ(1000), .PULSE_MS(N)) uut (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_flag(irq_flag),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // behavioural reference model
    bit m_pin, m_hi, m_lvl, m_pp, m_wk, m_sts;
    int m_mode = 0;   // 0 released, 1 timed, 2 held
    int m_left = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pin = 0; m_hi = 0; m_lvl = 0; m_pp = 0; m_wk = 0; m_sts = 0;
            m_mode = 0; m_left = 0;
        end else begin
            bit acc, rel, go;
            acc = wake_evt && m_wk;
            go  = acc && m_pin;
            rel = !m_sts || !m_wk || !m_pin;
            if (m_mode == 0) begin
                if (go) begin m_mode = m_lvl ? 2 : 1; m_left = N - 1; end
            end else if (rel) begin
                m_mode = 0;
            end else if (go) begin
                m_mode = m_lvl ? 2 : 1; m_left = N - 1;
            end else if (m_mode == 1) begin
                if (m_left == 0) m_mode = 0; else m_left--;
            end
            if (acc) m_sts = 1;
            else if (reg_wr && reg_wdata[3]) m_sts = 0;
            if (reg_wr) begin
                m_pin = reg_wdata[0]; m_hi = reg_wdata[1]; m_lvl = reg_wdata[2];
                m_pp = reg_wdata[4]; m_wk = reg_wdata[5];
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit act_m;
        int e_oe, e_out;
        act_m = (m_mode != 0) && m_pin && m_wk && m_sts;
        e_oe = 0; e_out = 0;
        if (m_pin) begin
            if (m_pp) begin e_oe = 1; e_out = act_m ? m_hi : !m_hi; end
            else e_oe = act_m;
        end
        chk(cur_req, "pad_oe", pad_oe, e_oe);
        chk(cur_req, "pad_out", pad_out, e_out);
        chk(cur_req, "irq_flag", irq_flag, m_sts);
        chk(cur_req, "reg_rdata", reg_rdata,
            {m_wk, m_pp, m_sts, m_lvl, m_hi, m_pin});
    end

    task automatic wr(input logic [5:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic ev();
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1", "rdata at reset", reg_rdata, 0);
        chk("R1", "pad_oe at reset", pad_oe, 0);
        chk("R1", "irq at reset", irq_flag, 0);
        rst_n = 1;
        idle(2);

        cur_req = "R3";
        wr(PIN | PP | HI);
        ev();
        chk("R3", "status after ignored event", irq_flag, 0);
        chk("R3", "pad_out after ignored event", pad_out, 0);

        cur_req = "R11";
        wr(WK | PP | HI);
        ev();
        chk("R2", "status with pin off", irq_flag, 1);
        chk("R11", "pad_oe with pin off", pad_oe, 0);
        cur_req = "R6";
        wr(WK | PP | HI | STS);
        chk("R6", "status after w1c", irq_flag, 0);

        cur_req = "R4";
        wr(WK | PIN | PP | HI);
        ev();
        chk("R9", "pp active high", pad_out, 1);
        idle(N - 1);
        chk("R4", "last pulse cycle", pad_out, 1);
        idle(1);
        chk("R4", "pulse ended", pad_out, 0);
        chk("R9", "pp oe when idle", pad_oe, 1);
        wr(WK | PIN | PP | HI | STS);

        cur_req = "R10";
        wr(WK | PIN | PP);
        ev();
        chk("R9", "pp active low", pad_out, 0);
        idle(3);
        ev();
        idle(N - 1);
        chk("R10", "retriggered pulse still on", pad_out, 0);
        idle(1);
        chk("R10", "retriggered pulse ended", pad_out, 1);
        wr(WK | PIN | PP | STS);

        cur_req = "R5";
        wr(WK | PIN | LVL | HI);
        ev();
        idle(3 * N);
        chk("R5", "level held", pad_oe, 1);
        chk("R8", "od drives low", pad_out, 0);
        wr(WK | PIN | LVL | HI);
        chk("R6", "write zero keeps level", pad_oe, 1);
        wr(WK | PIN | LVL | HI | STS);
        chk("R6", "w1c releases", pad_oe, 0);

        cur_req = "R7";
        ev();
        chk("R8", "od active", pad_oe, 1);
        wr(WK | LVL | HI);
        chk("R7", "pin off releases", pad_oe, 0);
        wr(WK | PIN | LVL | HI);
        chk("R7", "no reassert without event", pad_oe, 0);
        ev();
        wr(PIN | LVL | HI);
        chk("R7", "wake off releases", pad_oe, 0);
        wr(WK | PIN | LVL | STS);

        cur_req = "R6";
        @(negedge clk); wake_evt = 1; reg_wr = 1; reg_wdata = WK | PIN | LVL | STS;
        @(negedge clk); wake_evt = 0; reg_wr = 0; reg_wdata = '0;
        chk("R6", "event beats clear", irq_flag, 1);
        chk("R6", "event beats clear pin", pad_oe, 1);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule